// File: doc/BRIEF.md
# Recirculating Character Store

This block keeps one screen of text in serial form. It does not use addressable memory. Each bit of the character code has its own long shift register, called a bit-plane. All planes step together on a character strobe, so one whole code leaves the store per step. The bit that leaves each plane is written back into the tail of that plane, so the text loops forever without any system RAM. The code at the head feeds a glyph ROM outside this block, and that ROM feeds a pixel serializer.

The store has no address decoder. A 10-bit position counter records which slot is at the head. To change a character, the host posts a request that holds a slot number and a code, then waits while busy is high. The new code is put in place of the fed-back bits on the strobe where the counter equals the requested slot. That strobe is followed by a one-cycle done pulse.

Top module: `recirc_char_store`

## Requirements
- R1: After reset every slot holds the space code 6'h20, headPos is 0, and busy and wrDone are low.
- R2: Each cycle with charStrobe high advances headPos by one, wrapping from 1023 to 0. charOut then shows the next slot's code. Without a strobe, headPos and charOut hold.
- R3: With no write, each slot's code comes back unchanged at the head after 1024 strobes.
- R4: A wrReq seen while busy is low latches wrSlot and wrCode, and busy is high from the next cycle.
- R5: On the strobe where busy is high and headPos equals the latched slot, charOut still shows the old code. The latched code is stored in that slot, and it appears at the head on that slot's next pass.
- R6: wrDone is high for exactly the one cycle that follows the inserting strobe, and busy is low in that same cycle. wrDone is never high otherwise.
- R7: A wrReq seen while busy is high is dropped. The pending write keeps its slot and code, and no write follows it.
- R8: Only bits [5:0] of the 8-bit wrCode are stored. The upper bits are discarded.
- R9: A write changes only its target slot. Every other slot keeps its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| charStrobe | input | 1 | Advance the store one slot |
| wrReq | input | 1 | Post a write request (used only while idle) |
| wrSlot | input | 10 | Target slot of the write |
| wrCode | input | 8 | Character code to write; upper bits are dropped |
| charOut | output | 6 | Code of the slot now at the head |
| headPos | output | 10 | Slot number now at the head |
| busy | output | 1 | A write is pending |
| wrDone | output | 1 | One-cycle pulse after the write has been inserted |

## Verification
- **Per strobe:** charOut and headPos change at the clock edge that samples a strobe. The bench therefore checks the head code and slot in the low phase before that edge. It does this by popping a queued `{slot, code}` pair taken from a model array.
- **On a write request:** busy is due one edge after wrReq is sampled, and the bench checks it in the following low phase.
- **On insertion:** wrDone is due one edge after the inserting strobe, and the bench checks it in the low phase after that edge. The pulse must be gone one cycle later.
- **Content:** the model array is updated only at the inserting strobe. Full 1024-strobe passes then confirm the new code, the unchanged neighbours, and the dropped requests.

// File: rtl/recirc_char_store_pkg.sv
package recirc_char_store_pkg;

  // Strobes issued by the control to the bit-plane datapath
  typedef struct packed {
    logic shiftEn;   // advance every plane one step
    logic insertEn;  // replace fed-back bits with the pending code
  } storeCtrl_t;

endpackage

// File: rtl/recirc_char_ctrl.sv
module recirc_char_ctrl
  import recirc_char_store_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int CODE_W = 6,
  parameter int REQ_W  = 8,
  localparam int POS_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              charStrobe,
  input  logic              wrReq,
  input  logic [POS_W-1:0]  wrSlot,
  input  logic [REQ_W-1:0]  wrCode,
  output storeCtrl_t        ctrl,
  output logic [CODE_W-1:0] insCode,
  output logic [POS_W-1:0]  posCount,
  output logic              busy,
  output logic              wrDone
);

  logic [POS_W-1:0]  pendSlot;
  logic [CODE_W-1:0] pendCode;
  logic              slotHit;
  logic [POS_W-1:0]  posNext;

  assign slotHit       = busy && (posCount == pendSlot);
  assign ctrl.shiftEn  = charStrobe;
  assign ctrl.insertEn = charStrobe && slotHit;
  assign insCode       = pendCode;
  assign posNext       = (posCount == POS_W'(DEPTH - 1)) ? '0 : posCount + 1'b1;

  // Slot number now at the head
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           posCount <= '0;
    else if (charStrobe) posCount <= posNext;
  end

  // Pending write: accepted only while idle, cleared by the insertion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      pendSlot <= '0;
      pendCode <= '0;
    end else if (!busy) begin
      if (wrReq) begin
        busy     <= 1'b1;
        pendSlot <= wrSlot;
        pendCode <= wrCode[CODE_W-1:0];
      end
    end else if (ctrl.insertEn) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrDone <= 1'b0;
    else       wrDone <= ctrl.insertEn;
  end

endmodule

// File: rtl/recirc_char_planes.sv
module recirc_char_planes
  import recirc_char_store_pkg::*;
#(
  parameter int              DEPTH      = 1024,
  parameter int              CODE_W     = 6,
  parameter logic [CODE_W-1:0] SPACE_CODE = 6'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  storeCtrl_t        ctrl,
  input  logic [CODE_W-1:0] insCode,
  output logic [CODE_W-1:0] headChar
);

  // One serial ring per code bit; the head is the most significant stage
  for (genvar g = 0; g < CODE_W; g++) begin : g_plane
    logic [DEPTH-1:0] ring;
    logic             feedBit;

    assign feedBit     = ctrl.insertEn ? insCode[g] : ring[DEPTH-1];
    assign headChar[g] = ring[DEPTH-1];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             ring <= {DEPTH{SPACE_CODE[g]}};
      else if (ctrl.shiftEn) ring <= {ring[DEPTH-2:0], feedBit};
    end
  end

endmodule

// File: rtl/recirc_char_store.sv
module recirc_char_store
  import recirc_char_store_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int CODE_W = 6,
  parameter int REQ_W  = 8,
  parameter logic [CODE_W-1:0] SPACE_CODE = 6'h20,
  localparam int POS_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              charStrobe,
  input  logic              wrReq,
  input  logic [POS_W-1:0]  wrSlot,
  input  logic [REQ_W-1:0]  wrCode,
  output logic [CODE_W-1:0] charOut,
  output logic [POS_W-1:0]  headPos,
  output logic              busy,
  output logic              wrDone
);

  storeCtrl_t        ctrl;
  logic [CODE_W-1:0] insCode;

  recirc_char_ctrl #(.DEPTH(DEPTH), .CODE_W(CODE_W), .REQ_W(REQ_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .charStrobe(charStrobe), .wrReq(wrReq),
    .wrSlot(wrSlot), .wrCode(wrCode), .ctrl(ctrl), .insCode(insCode),
    .posCount(headPos), .busy(busy), .wrDone(wrDone)
  );

  recirc_char_planes #(.DEPTH(DEPTH), .CODE_W(CODE_W), .SPACE_CODE(SPACE_CODE)) planes_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .insCode(insCode), .headChar(charOut)
  );

endmodule

// File: rtl/recirc_char_store_chk.sv
module recirc_char_store_chk #(
  parameter int DEPTH = 1024,
  parameter int POS_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             charStrobe,
  input logic             wrReq,
  input logic [POS_W-1:0] headPos,
  input logic             busy,
  input logic             wrDone
);

  p_pos_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    charStrobe |=> headPos == (($past(headPos) == POS_W'(DEPTH - 1)) ? '0 : $past(headPos) + 1'b1));

  p_pos_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !charStrobe |=> $stable(headPos));

  p_busy_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrReq) |=> busy);

  p_wait_without_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !charStrobe) |=> busy && !wrDone);

  p_done_after_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrDone |-> ($past(busy) && $past(charStrobe) && !busy));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrDone |=> !wrDone);

  p_idle_no_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !wrReq) |=> !busy && !wrDone);

endmodule

bind recirc_char_store recirc_char_store_chk #(.DEPTH(DEPTH), .POS_W(POS_W)) chk_i (
  .clk(clk), .rstN(rstN), .charStrobe(charStrobe), .wrReq(wrReq),
  .headPos(headPos), .busy(busy), .wrDone(wrDone)
);

// File: tb/recirc_char_store_tb.sv
module recirc_char_store_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 1024;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       charStrobe = 1'b0;
  logic       wrReq = 1'b0;
  logic [9:0] wrSlot = '0;
  logic [7:0] wrCode = '0;
  logic [5:0] charOut;
  logic [9:0] headPos;
  logic       busy;
  logic       wrDone;

  int testsRun = 0;
  int testsFailed = 0;

  // Reference model
  logic [5:0] model [DEPTH];
  int         pos = 0;
  bit         pendValid = 0;
  int         pendSlot = 0;
  logic [5:0] pendCode = '0;
  int         expQ [$];  // {slot, code} packed as slot*64+code

  always #(CLK_PERIOD/2) clk = ~clk;

  recirc_char_store dut_i (
    .clk(clk), .rstN(rstN), .charStrobe(charStrobe), .wrReq(wrReq),
    .wrSlot(wrSlot), .wrCode(wrCode), .charOut(charOut), .headPos(headPos),
    .busy(busy), .wrDone(wrDone)
  );

  task automatic chk(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pop one expected head item per strobe (R2, R3, R5, R9)
  always @(negedge clk) begin
    if (rstN && charStrobe) begin
      if (expQ.size() == 0) chk("R2 queue underflow", 1, 0);
      else begin
        int item;
        item = expQ.pop_front();
        chk("R2 headPos", int'(headPos), item / 64);
        chk("R3/R5/R9 charOut", int'(charOut), item % 64);
      end
    end
  end

  // Driver: one strobe, then checks on the done pulse (R6)
  task automatic strobe();
    bit ins;
    ins = 0;
    @(posedge clk); #1;
    charStrobe = 1'b1;
    expQ.push_back(pos * 64 + int'(model[pos]));
    if (pendValid && pos == pendSlot) begin
      model[pos] = pendCode;
      pendValid  = 0;
      ins        = 1;
    end
    pos = (pos + 1) % DEPTH;
    @(posedge clk); #1;
    charStrobe = 1'b0;
    @(negedge clk);
    if (ins) begin
      chk("R6 wrDone after insert", int'(wrDone), 1);
      chk("R6 busy low with done", int'(busy), 0);
    end else if (wrDone) begin
      chk("R6 spurious wrDone", 1, 0);
    end
  endtask

  task automatic request(input int slot, input logic [7:0] code, input bit expectAccept);
    @(posedge clk); #1;
    wrReq = 1'b1; wrSlot = 10'(slot); wrCode = code;
    @(posedge clk); #1;
    wrReq = 1'b0;
    @(negedge clk);
    chk("R4 busy after request", int'(busy), 1);
    if (expectAccept) begin
      pendValid = 1; pendSlot = slot; pendCode = code[5:0];
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) strobe();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 6'h20;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 headPos", int'(headPos), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 wrDone", int'(wrDone), 0);
    chk("R1 charOut space", int'(charOut), 'h20);

    // R1/R2: a full pass of spaces, wrapping back to 0
    run(DEPTH);
    @(negedge clk);
    chk("R2 wrap to 0", int'(headPos), 0);

    // R2: hold without strobe
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R2 hold headPos", int'(headPos), 0);

    // R4, R8: write slot 5 with an 8-bit code, upper bits dropped
    request(5, 8'hC7, 1);
    run(2);
    // R7: a second request while busy is dropped
    request(6, 8'h15, 0);
    run(10);
    @(negedge clk);
    chk("R7 no second write pending", int'(busy), 0);
    // R8: the stored value shows up in the next pass
    run(DEPTH);

    // R5: write at last slot and at slot 0 (wrap boundary)
    request(1023, 8'h3F, 1);
    run(DEPTH - pos + 1);
    request(0, 8'h01, 1);
    run(DEPTH + 2);

    // R5: write the slot that is at the head right now
    request(pos, 8'h2A, 1);
    run(2);

    // R3/R9: two full passes verify every slot
    run(2 * DEPTH);
    chk("R3 scoreboard drained", expQ.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule